// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block turns the virtual address of an instruction fetch into a physical address by looking it up in a small set-associative table. Each table slot is a pair of 32-bit words. The match word holds a valid flag, a usage counter and the virtual page tag. The translate word holds the physical page, a cache-inhibit flag and two execute-permission flags, one for supervisor mode and one for user mode. A fetch request returns a registered response one cycle later. The response carries the physical address, the cache-inhibit flag, a hit flag and an exception code. Misses and permission failures are reported to software, which refills the table itself.

Software loads the table one word at a time through a configuration port. The port selects a way, a set, and either the match word or the translate word, and it reads the addressed word back combinationally. A separate probe input runs the same lookup and the same permission check with no side effects: it updates no usage counter, raises no exception and produces no response. When translation is switched off, or the translation unit is marked absent, addresses pass through unchanged and cache-inhibit follows the top address bit.

Top module: `itlb_xlate`

## Requirements
- R1: The set index is `(vaddr >> log2(PAGE_BYTES)) & (N_SETS-1)`. A way of that set hits only if bit 0 (valid) of its match word is 1 and `(match & VMASK) == (vaddr & VMASK)`, where `VMASK = ~(PAGE_BYTES*N_SETS-1)`.
- R2: When more than one way of the selected set hits, the lowest-numbered way supplies the translation.
- R3: On a translated hit, `rsp_paddr = (xlt & ~(PAGE_BYTES-1)) | (vaddr & (PAGE_BYTES-1))`, `rsp_ci` is bit 1 of the translate word, and `rsp_hit` is 1.
- R4: On a translated hit, the execute permission is bit 7 of the translate word in supervisor mode and bit 6 in user mode. If that bit is 0, `rsp_exc` is 2 (page fault), while `rsp_hit` stays 1 and the address is still translated. If the bit is 1, `rsp_exc` is 0.
- R5: On a translated miss, `rsp_exc` is 1, and `rsp_paddr`, `rsp_ci` and `rsp_hit` are all 0. The code 3 never appears.
- R6: When `mmu_en` or `mmu_present` is 0, the response is `rsp_paddr = vaddr`, `rsp_ci = vaddr[31]`, `rsp_hit = 0` and `rsp_exc = 0`. No usage counter changes.
- R7: A request presented at a clock edge produces its response, with `rsp_valid` high, at the next edge. `rsp_valid` is low after any edge without a request, and all response fields are then 0.
- R8: On a translated hit, the usage field (bits 7:6 of the match word) of the hit way is set to 3. Every other way of the same set whose usage field is nonzero is decremented by 1. Other sets are left unchanged.
- R9: `probe_paddr` is combinational. It equals `probe_vaddr` when translation is off, the translated address on a hit with permission, and 0 on a miss or a permission failure. It never changes table contents or response outputs.
- R10: When `cfg_we` is 1, `cfg_wdata` is written to the word selected by `cfg_way`, `cfg_set` and `cfg_xlt` (0 = match word, 1 = translate word). `cfg_rdata` shows the selected word. A lookup in the same cycle as a write uses the old contents, and the written value replaces any usage update to that word.
- R11: After reset every table word reads 0, which makes every slot invalid, and `rsp_valid` and `rsp_paddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch lookup request |
| req_vaddr | input | 32 | Fetch virtual address |
| mmu_en | input | 1 | Translation enabled |
| mmu_present | input | 1 | Translation unit implemented |
| sup_mode | input | 1 | Supervisor mode (1) or user mode (0) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 32 | Physical address |
| rsp_ci | output | 1 | Cache-inhibit flag |
| rsp_hit | output | 1 | Table hit |
| rsp_exc | output | 2 | 0 none, 1 table miss, 2 page fault |
| cfg_we | input | 1 | Table word write enable |
| cfg_way | input | WAY_BITS | Way select |
| cfg_set | input | SET_BITS | Set select |
| cfg_xlt | input | 1 | 0 match word, 1 translate word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Selected word, combinational |
| probe_vaddr | input | 32 | Side-effect-free probe address |
| probe_paddr | output | 32 | Probe result |

## Verification
The assertions assume that the mode inputs (`mmu_en`, `mmu_present`, `sup_mode`) are fixed for the cycle in which a request is sampled. They also assume that `PAGE_BYTES*N_SETS` is at least 256, so that the virtual tag bits never overlap the usage and valid bits. The bench uses 8 KiB pages, so the tag begins well above bit 7, and it changes the mode inputs only on falling edges, together with the request. Entry writes may touch usage and valid bits freely; the bench keeps its own copy of the table and applies every write to that copy.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  localparam int unsigned AW        = 32;
  localparam int unsigned VALID_BIT = 0;
  localparam int unsigned USE_LSB   = 6;
  localparam int unsigned USE_W     = 2;
  localparam int unsigned CI_BIT    = 1;
  localparam int unsigned UX_BIT    = 6;
  localparam int unsigned SX_BIT    = 7;

  typedef enum logic [1:0] {
    EXC_NONE   = 2'd0,
    EXC_MISS   = 2'd1,
    EXC_PFAULT = 2'd2
  } exc_e;

  // valid slot whose page tag equals the tag of va
  function automatic logic entry_matches(input logic [AW-1:0] m,
                                         input logic [AW-1:0] va,
                                         input logic [AW-1:0] vmask);
    return m[VALID_BIT] && ((m & vmask) == (va & vmask));
  endfunction

  function automatic logic [AW-1:0] make_pa(input logic [AW-1:0] x,
                                            input logic [AW-1:0] va,
                                            input logic [AW-1:0] offmask);
    return (x & ~offmask) | (va & offmask);
  endfunction

  function automatic logic exec_allowed(input logic [AW-1:0] x, input logic sup);
    return sup ? x[SX_BIT] : x[UX_BIT];
  endfunction

  // usage counter step: hit way reloads to max, others count down to zero
  function automatic logic [USE_W-1:0] usage_next(input logic [USE_W-1:0] u,
                                                  input logic is_hit_way);
    if (is_hit_way)   return '1;
    else if (u != '0) return u - 1'b1;
    else              return '0;
  endfunction

endpackage

// File: rtl/itlb_lookup.sv
module itlb_lookup
  import itlb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 8192,
  parameter int unsigned N_SETS     = 1,
  parameter int unsigned N_WAYS     = 1,
  localparam int unsigned WAY_BITS  = (N_WAYS > 1) ? $clog2(N_WAYS) : 1,
  localparam int unsigned SET_BITS  = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic [AW-1:0]                          va,
  input  logic                                   sup,
  input  logic [N_WAYS-1:0][N_SETS-1:0][AW-1:0]  tbl_m,
  input  logic [N_WAYS-1:0][N_SETS-1:0][AW-1:0]  tbl_x,
  output logic                                   hit,
  output logic [WAY_BITS-1:0]                    way,
  output logic [SET_BITS-1:0]                    set_idx,
  output logic [AW-1:0]                          pa,
  output logic                                   ci,
  output logic                                   perm
);

  localparam int unsigned   PG_LOG   = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] OFF_MASK = AW'(PAGE_BYTES - 1);
  localparam logic [AW-1:0] VPN_MASK = ~(AW'(PAGE_BYTES * N_SETS) - AW'(1));
  localparam logic [AW-1:0] SET_MASK = AW'(N_SETS - 1);

  logic [N_WAYS-1:0] way_match;
  logic [AW-1:0]     sel_x;

  assign set_idx = SET_BITS'((va >> PG_LOG) & SET_MASK);

  for (genvar w = 0; w < N_WAYS; w++) begin : g_way
    assign way_match[w] = entry_matches(tbl_m[w][set_idx], va, VPN_MASK);
  end

  always_comb begin
    hit = |way_match;
    way = '0;
    for (int w = N_WAYS - 1; w >= 0; w--) begin
      if (way_match[w]) way = WAY_BITS'(w);
    end
  end

  assign sel_x = tbl_x[way][set_idx];
  assign pa    = make_pa(sel_x, va, OFF_MASK);
  assign ci    = sel_x[CI_BIT];
  assign perm  = exec_allowed(sel_x, sup);

endmodule

// File: rtl/itlb_table.sv
module itlb_table
  import itlb_pkg::*;
#(
  parameter int unsigned N_SETS    = 1,
  parameter int unsigned N_WAYS    = 1,
  localparam int unsigned WAY_BITS = (N_WAYS > 1) ? $clog2(N_WAYS) : 1,
  localparam int unsigned SET_BITS = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   upd_en,
  input  logic [SET_BITS-1:0]                    upd_set,
  input  logic [WAY_BITS-1:0]                    upd_way,
  input  logic                                   wr_en,
  input  logic [WAY_BITS-1:0]                    sel_way,
  input  logic [SET_BITS-1:0]                    sel_set,
  input  logic                                   sel_xlt,
  input  logic [AW-1:0]                          wr_data,
  output logic [AW-1:0]                          rd_data,
  output logic [N_WAYS-1:0][N_SETS-1:0][AW-1:0]  tbl_m,
  output logic [N_WAYS-1:0][N_SETS-1:0][AW-1:0]  tbl_x
);

  logic sel_ok;
  assign sel_ok = (32'(sel_way) < N_WAYS) && (32'(sel_set) < N_SETS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_m <= '0;
      tbl_x <= '0;
    end else begin
      if (upd_en) begin
        for (int w = 0; w < N_WAYS; w++) begin
          tbl_m[w][upd_set][USE_LSB +: USE_W] <=
            usage_next(tbl_m[w][upd_set][USE_LSB +: USE_W], WAY_BITS'(w) == upd_way);
        end
      end
      // software write lands last, so it overrides a usage update
      if (wr_en && sel_ok) begin
        if (sel_xlt) tbl_x[sel_way][sel_set] <= wr_data;
        else         tbl_m[sel_way][sel_set] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_ok) rd_data = sel_xlt ? tbl_x[sel_way][sel_set] : tbl_m[sel_way][sel_set];
  end

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 8192,
  parameter int unsigned N_SETS     = 1,
  parameter int unsigned N_WAYS     = 1,
  localparam int unsigned WAY_BITS  = (N_WAYS > 1) ? $clog2(N_WAYS) : 1,
  localparam int unsigned SET_BITS  = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [31:0]         req_vaddr,
  input  logic                mmu_en,
  input  logic                mmu_present,
  input  logic                sup_mode,
  output logic                rsp_valid,
  output logic [31:0]         rsp_paddr,
  output logic                rsp_ci,
  output logic                rsp_hit,
  output logic [1:0]          rsp_exc,
  input  logic                cfg_we,
  input  logic [WAY_BITS-1:0] cfg_way,
  input  logic [SET_BITS-1:0] cfg_set,
  input  logic                cfg_xlt,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [31:0]         probe_vaddr,
  output logic [31:0]         probe_paddr
);

  logic [N_WAYS-1:0][N_SETS-1:0][AW-1:0] tbl_m, tbl_x;

  logic                xlate_on;
  logic                lu_hit, lu_ci, lu_perm;
  logic [WAY_BITS-1:0] lu_way;
  logic [SET_BITS-1:0] lu_set;
  logic [AW-1:0]       lu_pa;
  logic                pb_hit, pb_ci, pb_perm;
  logic [WAY_BITS-1:0] pb_way;
  logic [SET_BITS-1:0] pb_set;
  logic [AW-1:0]       pb_pa;
  logic                upd_en;

  logic [AW-1:0] nx_pa;
  logic          nx_ci, nx_hit;
  exc_e          nx_exc;

  assign xlate_on = mmu_en & mmu_present;
  assign upd_en   = req_valid & xlate_on & lu_hit;

  itlb_lookup #(.PAGE_BYTES(PAGE_BYTES), .N_SETS(N_SETS), .N_WAYS(N_WAYS)) u_lu_fetch (
    .va(req_vaddr), .sup(sup_mode), .tbl_m(tbl_m), .tbl_x(tbl_x),
    .hit(lu_hit), .way(lu_way), .set_idx(lu_set), .pa(lu_pa), .ci(lu_ci), .perm(lu_perm)
  );

  itlb_lookup #(.PAGE_BYTES(PAGE_BYTES), .N_SETS(N_SETS), .N_WAYS(N_WAYS)) u_lu_probe (
    .va(probe_vaddr), .sup(sup_mode), .tbl_m(tbl_m), .tbl_x(tbl_x),
    .hit(pb_hit), .way(pb_way), .set_idx(pb_set), .pa(pb_pa), .ci(pb_ci), .perm(pb_perm)
  );

  itlb_table #(.N_SETS(N_SETS), .N_WAYS(N_WAYS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .upd_set(lu_set), .upd_way(lu_way),
    .wr_en(cfg_we), .sel_way(cfg_way), .sel_set(cfg_set), .sel_xlt(cfg_xlt),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata),
    .tbl_m(tbl_m), .tbl_x(tbl_x)
  );

  always_comb begin
    nx_pa  = '0;
    nx_ci  = 1'b0;
    nx_hit = 1'b0;
    nx_exc = EXC_NONE;
    if (!xlate_on) begin
      nx_pa = req_vaddr;
      nx_ci = req_vaddr[31];
    end else if (lu_hit) begin
      nx_pa  = lu_pa;
      nx_ci  = lu_ci;
      nx_hit = 1'b1;
      nx_exc = lu_perm ? EXC_NONE : EXC_PFAULT;
    end else begin
      nx_exc = EXC_MISS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_ci    <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_exc   <= EXC_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_paddr <= req_valid ? nx_pa  : '0;
      rsp_ci    <= req_valid & nx_ci;
      rsp_hit   <= req_valid & nx_hit;
      rsp_exc   <= req_valid ? nx_exc : EXC_NONE;
    end
  end

  // probe: same lookup, no state touched
  assign probe_paddr = !xlate_on          ? probe_vaddr :
                       (pb_hit && pb_perm) ? pb_pa       : '0;

endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        mmu_en,
  input logic        mmu_present,
  input logic        rsp_valid,
  input logic [31:0] rsp_paddr,
  input logic        rsp_ci,
  input logic        rsp_hit,
  input logic [1:0]  rsp_exc,
  input logic        upd_en
);

  p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(mmu_en && mmu_present)) |=>
      (rsp_paddr == $past(req_vaddr) && rsp_ci == $past(req_vaddr[31]) &&
       rsp_exc == 2'd0 && !rsp_hit));

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc == 2'd1) |-> (rsp_paddr == 32'd0 && !rsp_hit && !rsp_ci));

  p_exc_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_exc != 2'd3);

  p_fault_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_exc == 2'd2) |-> rsp_hit);

  p_update_hits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (rsp_valid && rsp_hit));

endmodule

bind itlb_xlate itlb_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .mmu_en(mmu_en), .mmu_present(mmu_present), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci), .rsp_hit(rsp_hit), .rsp_exc(rsp_exc),
  .upd_en(upd_en)
);

// File: tb/itlb_xlate_tb.sv
module itlb_xlate_tb;

  localparam int PB = 8192;
  localparam int NS = 4;
  localparam int NW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        mmu_en = 1'b0, mmu_present = 1'b0, sup_mode = 1'b0;
  logic        rsp_valid, rsp_ci, rsp_hit;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_exc;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_way = '0;
  logic [1:0]  cfg_set = '0;
  logic        cfg_xlt = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] probe_vaddr = '0;
  logic [31:0] probe_paddr;

  itlb_xlate #(.PAGE_BYTES(PB), .N_SETS(NS), .N_WAYS(NW)) u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mm [NW][NS];
  logic [31:0] mx [NW][NS];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] vpn_tag(int w, int s);
    return 32'((w * 7 + s * 3 + 1) << 15);
  endfunction

  // bench-side lookup computed from the requirements
  task automatic expect_lu(input logic [31:0] va, input logic sup,
                           output bit hit, output int way, output logic [31:0] pa,
                           output logic ci, output logic [1:0] exc);
    int s = int'((va / PB) % NS);
    logic [31:0] tagmask = ~(32'(PB * NS) - 1);
    hit = 0; way = 0; pa = 0; ci = 0; exc = 2'd1;
    for (int w = NW - 1; w >= 0; w--)
      if (mm[w][s][0] && ((mm[w][s] & tagmask) == (va & tagmask))) begin hit = 1; way = w; end
    if (hit) begin
      pa  = (mx[way][s] / PB) * PB + (va % PB);
      ci  = mx[way][s][1];
      exc = (sup ? mx[way][s][7] : mx[way][s][6]) ? 2'd0 : 2'd2;
    end
  endtask

  task automatic mdl_touch(int s, int hw);
    for (int w = 0; w < NW; w++) begin
      logic [1:0] u = mm[w][s][7:6];
      if (w == hw) u = 2'd3; else if (u != 0) u = u - 2'd1;
      mm[w][s][7:6] = u;
    end
  endtask

  task automatic cfg_write(int w, int s, bit x, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_way = 1'(w); cfg_set = 2'(s); cfg_xlt = x; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (x) mx[w][s] = d; else mm[w][s] = d;
  endtask

  task automatic cfg_read(int w, int s, bit x, output logic [31:0] d);
    @(negedge clk);
    cfg_way = 1'(w); cfg_set = 2'(s); cfg_xlt = x;
    #1 d = cfg_rdata;
  endtask

  task automatic check_table(string req);
    logic [31:0] d;
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) begin
        cfg_read(w, s, 0, d); chk(req, d, mm[w][s]);
      end
  endtask

  task automatic lookup(logic [31:0] va, bit en, bit pres, bit sup, string req);
    bit hit; int way; logic [31:0] pa; logic ci; logic [1:0] exc;
    @(negedge clk);
    mmu_en = en; mmu_present = pres; sup_mode = sup;
    req_valid = 1; req_vaddr = va;
    if (en && pres) expect_lu(va, sup, hit, way, pa, ci, exc);
    else begin hit = 0; way = 0; pa = va; ci = va[31]; exc = 2'd0; end
    @(negedge clk);
    req_valid = 0;
    chk({req, " R7 valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " paddr"},    rsp_paddr, pa);
    chk({req, " ci"},       32'(rsp_ci), 32'(ci));
    chk({req, " hit"},      32'(rsp_hit), 32'(hit));
    chk({req, " exc"},      32'(rsp_exc), 32'(exc));
    if (en && pres && hit) mdl_touch(int'((va / PB) % NS), way);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] offs [3] = '{32'h0, 32'h1abc, 32'h1fff};
    logic [31:0] ptv [5] = '{32'h0, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h0};
    for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin mm[w][s] = 0; mx[w][s] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    #1;
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11 rsp_paddr", rsp_paddr, 32'd0);
    check_table("R11 match word");
    for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin
      cfg_read(w, s, 1, d); chk("R11 translate word", d, 32'd0);
    end

    // R10: load every slot through the configuration port
    for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin
      logic [31:0] x = 32'((w * 4 + s + 16) * PB);
      x[1] = 1'((w + s) & 1);
      x[6] = ((w + s) % 3) != 0;
      x[7] = (s != 2);
      cfg_write(w, s, 0, vpn_tag(w, s) | 32'd1);
      cfg_write(w, s, 1, x);
    end
    for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) begin
      cfg_read(w, s, 1, d); chk("R10 readback translate", d, mx[w][s]);
    end
    check_table("R10 readback match");

    // R1 R3 R4 R8: hit sweep over every slot, both modes, three offsets
    for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++)
      for (int sup = 0; sup < 2; sup++) for (int o = 0; o < 3; o++) begin
        lookup(vpn_tag(w, s) | 32'(s * PB) | offs[o], 1, 1, 1'(sup), "R3 R4 hit sweep");
        cfg_read(0, s, 0, d); chk("R8 usage way0", d, mm[0][s]);
        cfg_read(1, s, 0, d); chk("R8 usage way1", d, mm[1][s]);
      end
    check_table("R8 other sets untouched");

    // R5 R1: misses (unknown tag, wrong set, invalid slot)
    for (int s = 0; s < NS; s++) lookup(32'h0080_0000 | 32'(s * PB) | 32'h44, 1, 1, 0, "R5 miss unknown tag");
    lookup(vpn_tag(0, 0) | 32'(1 * PB), 1, 1, 1, "R1 wrong set");
    cfg_write(1, 2, 0, mm[1][2] & ~32'd1);
    lookup(vpn_tag(1, 2) | 32'(2 * PB) | 32'h10, 1, 1, 1, "R1 invalid slot miss");
    check_table("R5 miss leaves table");

    // R6: pass-through in all off combinations
    ptv[4] = vpn_tag(0, 1) | 32'(PB);
    for (int i = 0; i < 5; i++) begin
      lookup(ptv[i], 0, 1, 1, "R6 disabled");
      lookup(ptv[i], 1, 0, 0, "R6 absent");
      lookup(ptv[i], 0, 0, 1, "R6 both off");
    end
    check_table("R6 no usage change");

    // R7: strobe is a single cycle
    lookup(vpn_tag(0, 3) | 32'(3 * PB), 1, 1, 1, "R7 pulse");
    @(negedge clk);
    chk("R7 strobe low", 32'(rsp_valid), 32'd0);
    chk("R7 fields cleared", rsp_paddr, 32'd0);

    // R9: probe
    for (int w = 0; w < NW; w++) for (int s = 0; s < NS; s++) for (int sup = 0; sup < 2; sup++) begin
      bit hit; int way; logic [31:0] pa; logic ci; logic [1:0] exc;
      logic [31:0] va = vpn_tag(w, s) | 32'(s * PB) | 32'h123;
      @(negedge clk);
      mmu_en = 1; mmu_present = 1; sup_mode = 1'(sup); probe_vaddr = va;
      expect_lu(va, 1'(sup), hit, way, pa, ci, exc);
      #1 chk("R9 probe on", probe_paddr, (hit && exc == 2'd0) ? pa : 32'd0);
      chk("R9 probe no response", 32'(rsp_valid), 32'd0);
    end
    @(negedge clk);
    probe_vaddr = 32'h0080_0000;
    #1 chk("R9 probe miss", probe_paddr, 32'd0);
    @(negedge clk);
    mmu_en = 0; probe_vaddr = 32'h8123_4567;
    #1 chk("R9 probe off", probe_paddr, 32'h8123_4567);
    check_table("R9 probe leaves usage");

    // R2: duplicate tag in a set, lowest way wins
    cfg_write(1, 0, 0, vpn_tag(0, 0) | 32'd1);
    lookup(vpn_tag(0, 0) | 32'h0abc, 1, 1, 1, "R2 lowest way");
    cfg_write(0, 0, 0, 32'd0);
    lookup(vpn_tag(0, 0) | 32'h0abc, 1, 1, 1, "R2 way1 after clear");

    // R10: write to the same set during a lookup
    begin
      bit hit; int way; logic [31:0] pa; logic ci; logic [1:0] exc;
      logic [31:0] nd = vpn_tag(1, 3) | 32'h1;
      logic [31:0] va = vpn_tag(0, 1) | 32'(PB) | 32'h77;
      @(negedge clk);
      mmu_en = 1; mmu_present = 1; sup_mode = 1;
      expect_lu(va, 1, hit, way, pa, ci, exc);
      req_valid = 1; req_vaddr = va;
      cfg_we = 1; cfg_way = 0; cfg_set = 1; cfg_xlt = 0; cfg_wdata = nd;
      @(negedge clk);
      req_valid = 0; cfg_we = 0;
      chk("R10 collision old paddr", rsp_paddr, pa);
      chk("R10 collision old hit", 32'(rsp_hit), 32'(hit));
      if (hit) mdl_touch(1, way);
      mm[0][1] = nd;
      check_table("R10 write wins");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule